// File: doc/BRIEF.md
# Row Address Sequencer for Pattern Loading

This block decides which row of a micromirror-style display array receives each row of binary pattern data. Pattern data streams in one row per row cycle. In the same cycle as each row's data, the source presents a two-bit row-mode code, a direction bit and, when needed, an explicit row address. The sequencer registers these inputs. On the next cycle it presents the resolved row address and a one-cycle write strobe to the array-side interface.

Four modes are available: hold (no write), step one row from the previous address, jump to a supplied address, or restart at the top or bottom edge. The direction bit selects the edge for a restart and the sign of a step. A step never wraps past either edge. A jump never lands outside the array. Either event instead raises a sticky out-of-range flag, which only reset clears. The row count is a parameter, and the address width is derived from it.

Top module: `row_seq_top`

## Requirements
- R1: While reset is held, and after it is released, wr_stb is 0, wr_addr is 0 and oor_flag is 0 until the first row cycle is captured. Reset is asserted asynchronously and released through a two-stage synchroniser.
- R2: A row cycle whose mode is not 00 raises wr_stb for exactly one clock, in the cycle after the inputs are captured, with wr_addr valid in that same cycle.
- R3: Mode 00 (no-op) produces no write strobe and leaves wr_addr unchanged.
- R4: Mode 01 (step) with row_dir=0 sets wr_addr to the previous address plus one. With row_dir=1 it sets wr_addr to the previous address minus one.
- R5: Mode 11 (restart) with row_dir=0 sets wr_addr to 0, the top row. With row_dir=1 it sets wr_addr to ROWS-1, the bottom row.
- R6: Mode 10 (jump) sets wr_addr to row_addr_in when row_addr_in is below ROWS.
- R7: A step up from ROWS-1, or a step down from 0, keeps the address at that edge, still asserts wr_stb and sets oor_flag.
- R8: A jump to an address of ROWS or above writes row ROWS-1 and sets oor_flag.
- R9: Once set, oor_flag stays 1 until reset, and wr_addr is always below ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_mode | input | 2 | Row-mode code: 00 no-op, 01 step, 10 jump, 11 restart |
| row_dir | input | 1 | 0 selects top edge or upward step, 1 selects bottom edge or downward step |
| row_addr_in | input | AW | Explicit row address used by the jump mode |
| wr_stb | output | 1 | One-cycle row write strobe |
| wr_addr | output | AW | Resolved target row address |
| oor_flag | output | 1 | Sticky out-of-range indication |

## Verification
Several properties are checked on every cycle:
- a strobe follows every non-hold row cycle;
- the address is held and no strobe appears after a hold;
- a jump to an in-range address lands on that address;
- an upward step from inside the array adds exactly one;
- the address never leaves the array, and the flag never drops.

Other behaviours can only be shown by the bench's scenarios, which walk the array in sequences. These are saturation at both edges, clamping of an oversized jump, restarts in both directions, and the flag being cleared by a reset in the middle of a run.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD    = 2'b00,
    MODE_STEP    = 2'b01,
    MODE_JUMP    = 2'b10,
    MODE_RESTART = 2'b11
  } row_mode_e;
endpackage

// File: rtl/row_seq_rst_sync.sv
module row_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/row_seq_next.sv
module row_seq_next
  import row_seq_pkg::*;
#(
  parameter int ROWS = 1080,
  parameter int AW   = $clog2(ROWS)
) (
  input  logic [1:0]    mode,
  input  logic          dir,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] cur,
  output logic          wr,
  output logic          hit,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] LAST = AW'(ROWS - 1);

  always_comb begin
    wr  = 1'b1;
    hit = 1'b0;
    nxt = cur;
    unique case (row_mode_e'(mode))
      MODE_HOLD: begin
        wr = 1'b0;
      end
      MODE_STEP: begin
        if (!dir) begin
          if (cur >= LAST) hit = 1'b1;
          else             nxt = cur + AW'(1);
        end else begin
          if (cur == '0) hit = 1'b1;
          else           nxt = cur - AW'(1);
        end
      end
      MODE_JUMP: begin
        if (addr_in > LAST) begin
          hit = 1'b1;
          nxt = LAST;
        end else begin
          nxt = addr_in;
        end
      end
      MODE_RESTART: begin
        nxt = dir ? LAST : '0;
      end
      default: wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/row_seq_top.sv
module row_seq_top #(
  parameter int ROWS = 1080
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               row_mode,
  input  logic                     row_dir,
  input  logic [$clog2(ROWS)-1:0]  row_addr_in,
  output logic                     wr_stb,
  output logic [$clog2(ROWS)-1:0]  wr_addr,
  output logic                     oor_flag
);
  localparam int AW = $clog2(ROWS);

  logic          srst_n;
  logic          nx_wr;
  logic          nx_hit;
  logic [AW-1:0] nx_addr;

  logic          stb_q, stb_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          oor_q, oor_d;
  logic          addr_en;

  row_seq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  row_seq_next #(.ROWS(ROWS), .AW(AW)) u_next (
    .mode    (row_mode),
    .dir     (row_dir),
    .addr_in (row_addr_in),
    .cur     (addr_q),
    .wr      (nx_wr),
    .hit     (nx_hit),
    .nxt     (nx_addr)
  );

  always_comb begin
    stb_d   = nx_wr;
    addr_en = nx_wr;
    addr_d  = nx_addr;
    oor_d   = oor_q | nx_hit;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      stb_q  <= 1'b0;
      addr_q <= '0;
      oor_q  <= 1'b0;
    end else begin
      stb_q <= stb_d;
      oor_q <= oor_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign wr_stb   = stb_q;
  assign wr_addr  = addr_q;
  assign oor_flag = oor_q;
endmodule

// File: rtl/row_seq_chk.sv
module row_seq_chk #(
  parameter int ROWS = 1080,
  parameter int AW   = $clog2(ROWS)
) (
  input logic          clk,
  input logic          srst_n,
  input logic [1:0]    row_mode,
  input logic          row_dir,
  input logic [AW-1:0] row_addr_in,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic          oor_flag
);
  localparam logic [AW-1:0] LAST = AW'(ROWS - 1);

  p_strobe_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (row_mode != 2'b00) |=> wr_stb);

  p_hold_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (row_mode == 2'b00) |=> (!wr_stb && $stable(wr_addr)));

  p_step_up_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (row_mode == 2'b01 && !row_dir && wr_addr < LAST)
      |=> (wr_addr == AW'($past(wr_addr) + AW'(1))));

  p_jump_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (row_mode == 2'b10 && row_addr_in <= LAST)
      |=> (wr_addr == $past(row_addr_in)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!srst_n)
    oor_flag |=> oor_flag);

  p_in_range_r9: assert property (@(posedge clk) disable iff (!srst_n)
    wr_addr <= LAST);
endmodule

bind row_seq_top row_seq_chk #(.ROWS(ROWS), .AW(AW)) chk_i (
  .clk         (clk),
  .srst_n      (srst_n),
  .row_mode    (row_mode),
  .row_dir     (row_dir),
  .row_addr_in (row_addr_in),
  .wr_stb      (wr_stb),
  .wr_addr     (wr_addr),
  .oor_flag    (oor_flag)
);

// File: tb/row_seq_top_tb_top.sv
`timescale 1ns/1ps
module row_seq_top_tb_top;
  localparam int ROWS = 1080;
  localparam int AW   = $clog2(ROWS);

  typedef struct {
    logic          stb;
    logic [AW-1:0] addr;
    logic          oor;
    string         tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic [1:0]    row_mode;
  logic          row_dir;
  logic [AW-1:0] row_addr_in;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic          oor_flag;

  int   n_total;
  int   n_fail;
  exp_t q[$];
  int   m_addr;
  logic m_oor;

  row_seq_top #(.ROWS(ROWS)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_mode    (row_mode),
    .row_dir     (row_dir),
    .row_addr_in (row_addr_in),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .oor_flag    (oor_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one row cycle and pushes the expected result.
  task automatic drive(input logic [1:0] mode, input logic dir, input int addr, input string tag);
    exp_t e;
    logic stb;
    @(negedge clk);
    row_mode    = mode;
    row_dir     = dir;
    row_addr_in = AW'(addr);
    stb = (mode != 2'b00);
    case (mode)
      2'b01: begin
        if (!dir) begin
          if (m_addr == ROWS - 1) m_oor = 1'b1; else m_addr = m_addr + 1;
        end else begin
          if (m_addr == 0) m_oor = 1'b1; else m_addr = m_addr - 1;
        end
      end
      2'b10: begin
        if (addr >= ROWS) begin m_addr = ROWS - 1; m_oor = 1'b1; end
        else m_addr = addr;
      end
      2'b11: m_addr = dir ? ROWS - 1 : 0;
      default: ;
    endcase
    e.stb = stb; e.addr = AW'(m_addr); e.oor = m_oor; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: takes the item captured at this edge, compares half a cycle later.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        @(negedge clk);
        check(e.tag, "wr_stb",   int'(wr_stb),   int'(e.stb));
        check(e.tag, "wr_addr",  int'(wr_addr),  int'(e.addr));
        check(e.tag, "oor_flag", int'(oor_flag), int'(e.oor));
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    row_mode = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    row_mode = 2'b00;
    m_addr = 0;
    m_oor = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "wr_stb in reset",   int'(wr_stb),   0);
    check("R1", "wr_addr in reset",  int'(wr_addr),  0);
    check("R1", "oor_flag in reset", int'(oor_flag), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "wr_stb after release",  int'(wr_stb),  0);
    check("R1", "wr_addr after release", int'(wr_addr), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_total++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    n_total = 0; n_fail = 0;
    m_addr = 0; m_oor = 1'b0;
    rst_n = 1'b0; row_mode = 2'b00; row_dir = 1'b0; row_addr_in = '0;
    do_reset();

    drive(2'b11, 1'b0, 0, "R5");
    for (int i = 0; i < 5; i++) drive(2'b01, 1'b0, 0, "R4");
    drive(2'b00, 1'b0, 700, "R3");
    drive(2'b00, 1'b1, 0, "R3");
    drive(2'b01, 1'b1, 0, "R4");
    drive(2'b10, 1'b0, 517, "R6");
    drive(2'b00, 1'b0, 0, "R2");
    drive(2'b10, 1'b1, ROWS - 1, "R6");
    drive(2'b11, 1'b1, 3, "R5");
    drive(2'b01, 1'b1, 0, "R4");
    drive(2'b01, 1'b0, 0, "R4");
    drive(2'b01, 1'b0, 0, "R7");
    drive(2'b01, 1'b0, 0, "R7");
    drive(2'b11, 1'b0, 0, "R9");
    drive(2'b01, 1'b1, 0, "R7");
    drive(2'b10, 1'b0, 42, "R9");
    drain();

    do_reset();
    drive(2'b10, 1'b0, 2047, "R8");
    drive(2'b10, 1'b0, ROWS, "R8");
    drive(2'b01, 1'b1, 0, "R4");
    drive(2'b00, 1'b0, 0, "R3");
    drain();

    do_reset();
    drive(2'b01, 1'b1, 0, "R7");
    drive(2'b01, 1'b0, 0, "R4");
    drain();

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule